// File: doc/BRIEF.md
# Dual-Role Synchronous Serial Port

This block moves 8-bit frames over a four-wire synchronous serial link and can act as either end of it. A processor talks to it through a small register window: it writes bytes into an 8-entry transmit queue, takes received bytes from an 8-entry receive queue, and reads one status register for queue levels, activity and a receive overrun flag.

As bus master, the port makes the serial clock from the system clock through a programmable divider. It drives an active-low frame select around every byte and supports all four combinations of clock polarity and clock phase. As bus slave, it follows an external clock and an external select. It runs with the serial clock idle low and takes data on the first edge only. A request for any other slave timing is refused when the control register is written. In both roles a separate output-enable pin tells the pad when the port is driving its data line.

Top module: `sxp_port`

## Requirements
- R1: Register window at reg_addr: 0 = data (a write queues a transmit byte, a read returns and removes the oldest received byte), 1 = control (bit0 enable, bit1 slave role, bit2 clock polarity, bit3 clock phase), 2 = divider, 3 = status (bit0 transmit queue empty, bit1 transmit queue full, bit2 receive queue empty, bit3 receive queue full, bit4 busy, bit5 overrun; writing 1 to bit5 clears it). After reset, control and divider read 0, status reads 0x05, sel_n_o is high, sclk_o is low and ser_tx_oe is low.
- R2: In the master role every frame holds sel_n_o low while exactly 16 serial clock edges occur, and it sends the 8 data bits on ser_tx with the most significant bit first.
- R3: In the master role sclk_o rests at the polarity bit whenever sel_n_o is high. With phase 0, data is sampled on the first edge of each bit and ser_tx changes on the second edge. With phase 1, data is sampled on the second edge and ser_tx changes on the first.
- R4: In the master role the first clock edge comes DIV+1 system clocks after sel_n_o falls, and every later edge comes DIV+1 system clocks after the one before it. DIV=0 therefore gives the minimum of 2 system clocks per serial clock.
- R5: The master opens a frame only while the transmit queue holds a byte. It sends queued bytes back to back, with sel_n_o high for at least one cycle between frames, and it leaves the clock idle once the queue is empty.
- R6: A received byte enters the receive queue after its 8th sampling edge. Data reads return the bytes oldest first, and the queue holds 8 of them.
- R7: A byte that completes while the receive queue is full is discarded and sets the overrun flag. The flag holds until software clears it.
- R8: The transmit queue holds 8 bytes and shows full in the status register. A data write while it is full is dropped.
- R9: In the slave role the port samples ser_rx on rising sclk_i edges while sel_n_i is low, and it shifts its transmit byte out on ser_tx, most significant bit first, changing on falling edges. It loads the first byte when the select falls and the next byte after each 8th rising edge.
- R10: Writing control with the slave bit set stores polarity 0 and phase 0, whatever the polarity and phase bits written.
- R11: ser_tx_oe is high exactly while the port drives ser_tx: in the master role while sel_n_o is low, in the slave role while the synchronised sel_n_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at the data address) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| sclk_o | output | 1 | Serial clock driven in the master role |
| sel_n_o | output | 1 | Frame select driven in the master role, active low |
| sclk_i | input | 1 | Serial clock received in the slave role |
| sel_n_i | input | 1 | Frame select received in the slave role, active low |
| ser_tx | output | 1 | Serial transmit data |
| ser_tx_oe | output | 1 | High while ser_tx is actively driven |
| ser_rx | input | 1 | Serial receive data |

## Verification
The bench acts as a clocked peer that samples ser_tx only on the edges the selected phase calls for. A master that shifted on the wrong edge, or that left out the first-edge shift skip for phase 1, would hand over rotated or shifted bytes. The bench also times every clock edge against the divider, so an off-by-one in the half-period counter shows up as a wrong spacing even at the minimum ratio. It fills both queues to their ends: a ninth queued byte must not reach the wire, and a ninth received byte must raise overrun without displacing the eight bytes already held. In slave mode it asks for a timing that is not allowed and checks that the control register reads it back as polarity 0 and phase 0. It then sends two bytes under one select, which catches a reload of the second transmit byte at the wrong edge.

// File: rtl/sxp_pkg.sv
// Shared constants and types for the dual-role serial port.
// Assumes register data is at least 8 bits wide so all control and
// status bits fit into one register word.
package sxp_pkg;

    // Register addresses inside the window
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    // Control bit positions
    localparam int CB_EN  = 0;
    localparam int CB_SLV = 1;
    localparam int CB_POL = 2;
    localparam int CB_PHA = 3;

    // Status bit positions
    localparam int SB_TXE  = 0;
    localparam int SB_TXF  = 1;
    localparam int SB_RXE  = 2;
    localparam int SB_RXF  = 3;
    localparam int SB_BUSY = 4;
    localparam int SB_OVR  = 5;

    // Master sequencer states
    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RUN  = 2'd1,
        M_TAIL = 2'd2
    } mst_state_t;

endpackage

// File: rtl/sxp_fifo.sv
// Byte queue with registered pointers and an occupancy counter.
// Assumes DEPTH >= 2. A push while full and a pop while empty are ignored.
// rdata shows the oldest entry combinationally.
module sxp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= wdata;
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST_P) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST_P) ? '0 : rptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8 / R6: a push against a full queue leaves it full and unchanged in size
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && $stable(wptr)));

    // R6: occupancy never goes beyond the depth
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

endmodule

// File: rtl/sxp_master.sv
// Master-role engine: opens a frame when a transmit byte is waiting,
// makes 2*DATA_W serial clock edges spaced DIV+1 system clocks apart,
// shifts data out most significant bit first and samples ser_rx on the
// edges chosen by the phase bit. Assumes polarity, phase and divider do
// not change while a frame is open, and that the peer's data is
// synchronous to the clock this engine produces.
module sxp_master #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  div,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rxd,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              sel_n,
    output logic              txd,
    output logic              busy
);

    import sxp_pkg::*;

    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    mst_state_t        state;
    logic [DIV_W-1:0]  cnt;
    logic              level;
    logic [EW-1:0]     edge_idx;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              sel_n_q;
    logic              tick;
    logic              is_sample;
    logic              is_shift;
    logic              last_sample;
    logic              start;

    assign tick        = (cnt == div);
    assign start       = (state == M_IDLE) && run && !tx_empty;
    assign is_sample   = (edge_idx[0] == cpha);
    assign is_shift    = !is_sample && !(cpha && (edge_idx == '0));
    assign last_sample = (edge_idx == (cpha ? LAST_EDGE : LAST_EDGE - 1'b1));

    assign tx_pop  = start;
    assign rx_push = (state == M_RUN) && tick && is_sample && last_sample;
    assign rx_data = {rx_sh[DATA_W-2:0], rxd};
    assign sclk    = cpol ^ level;
    assign sel_n   = sel_n_q;
    assign txd     = tx_sh[DATA_W-1];
    assign busy    = (state != M_IDLE);

    // Frame sequencer: divider count, edge count, shift registers, select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= M_IDLE;
            cnt      <= '0;
            level    <= 1'b0;
            edge_idx <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sel_n_q  <= 1'b1;
        end else begin
            case (state)
                M_IDLE: begin
                    if (start) begin
                        state    <= M_RUN;
                        tx_sh    <= tx_data;
                        sel_n_q  <= 1'b0;
                        cnt      <= '0;
                        edge_idx <= '0;
                        level    <= 1'b0;
                    end
                end
                M_RUN: begin
                    if (tick) begin
                        cnt      <= '0;
                        level    <= ~level;
                        edge_idx <= edge_idx + 1'b1;
                        if (is_sample) begin
                            rx_sh <= {rx_sh[DATA_W-2:0], rxd};
                        end
                        if (is_shift) begin
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        end
                        if (edge_idx == LAST_EDGE) begin
                            state <= M_TAIL;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_TAIL: begin
                    if (tick) begin
                        cnt     <= '0;
                        state   <= M_IDLE;
                        sel_n_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    // R3: with the select high the clock rests at the polarity level
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_q |-> (sclk == cpol));

    // R5: a frame only opens when a byte was waiting and the engine ran
    a_r5_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n_q) |-> $past(run && !tx_empty));

    // R6: a receive push happens only inside an open frame
    a_r6_push_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !sel_n_q);

endmodule

// File: rtl/sxp_slave.sv
// Slave-role engine for idle-low clock, first-edge sampling. Brings the
// external clock, select and data into the system clock domain with
// two flops, detects edges there, samples on rising edges and shifts
// on falling edges. Assumes the external clock half period is at least
// three system clocks. An empty transmit queue sends zeros.
module sxp_slave #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sclk_in,
    input  logic              sel_n_in,
    input  logic              rxd_in,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              txd,
    output logic              active
);

    localparam int CNTW = $clog2(DATA_W);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DATA_W - 1);

    logic [2:0]        sclk_s;
    logic [2:0]        sel_s;
    logic [1:0]        rxd_s;
    logic [CNTW-1:0]   bit_cnt;
    logic              reload;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              rise;
    logic              fall;
    logic              sel_low;
    logic              sel_fall;
    logic              load;
    logic [DATA_W-1:0] next_byte;

    assign rise      = sclk_s[1] && !sclk_s[2];
    assign fall      = !sclk_s[1] && sclk_s[2];
    assign sel_low   = !sel_s[1];
    assign sel_fall  = !sel_s[1] && sel_s[2];
    assign load      = run && (sel_fall || (sel_low && fall && reload));
    assign next_byte = tx_empty ? '0 : tx_data;

    assign tx_pop  = load && !tx_empty;
    assign rx_push = run && sel_low && rise && (bit_cnt == LAST_BIT);
    assign rx_data = {rx_sh[DATA_W-2:0], rxd_s[1]};
    assign txd     = tx_sh[DATA_W-1];
    assign active  = run && sel_low;

    // Input synchronisers for the external pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= 3'b000;
            sel_s  <= 3'b111;
            rxd_s  <= 2'b00;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk_in};
            sel_s  <= {sel_s[1:0], sel_n_in};
            rxd_s  <= {rxd_s[0], rxd_in};
        end
    end

    // Bit engine: load on select fall, sample on rise, shift or reload on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            reload  <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (run && sel_fall) begin
            bit_cnt <= '0;
            reload  <= 1'b0;
            tx_sh   <= next_byte;
        end else if (run && sel_low) begin
            if (rise) begin
                rx_sh <= {rx_sh[DATA_W-2:0], rxd_s[1]};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= '0;
                    reload  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (fall) begin
                if (reload) begin
                    tx_sh  <= next_byte;
                    reload <= 1'b0;
                end else begin
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // R9: bytes are only taken from the transmit queue inside a selected frame
    a_r9_pop_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (sel_low && run));

    // R9: the outgoing bit holds still across a rising (sampling) edge
    a_r9_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel_low && !sel_fall && rise) |=> $stable(tx_sh));

endmodule

// File: rtl/sxp_port.sv
// Top of the dual-role serial port: register window, both queues and
// the choice between master and slave engines. Assumes DATA_W and DIV_W
// do not exceed REG_W and that software changes role, polarity, phase
// and divider only while the port is idle.
module sxp_port #(
    parameter int REG_W      = 8,
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sclk_o,
    output logic             sel_n_o,
    input  logic             sclk_i,
    input  logic             sel_n_i,
    output logic             ser_tx,
    output logic             ser_tx_oe,
    input  logic             ser_rx
);

    import sxp_pkg::*;

    logic              en_q;
    logic              slv_q;
    logic              cpol_q;
    logic              cpha_q;
    logic [DIV_W-1:0]  div_q;
    logic              ovr_q;

    logic              wr_data;
    logic              wr_ctrl;
    logic              wr_div;
    logic              wr_stat;
    logic              rd_data;
    logic              run_m;
    logic              run_s;

    logic              tx_full;
    logic              tx_empty;
    logic [DATA_W-1:0] tx_head;
    logic              tx_pop;
    logic              rx_full;
    logic              rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              rx_push_any;
    logic [DATA_W-1:0] rx_byte;

    logic              m_pop;
    logic              m_push;
    logic [DATA_W-1:0] m_rx;
    logic              m_sclk;
    logic              m_sel_n;
    logic              m_txd;
    logic              m_busy;
    logic              s_pop;
    logic              s_push;
    logic [DATA_W-1:0] s_rx;
    logic              s_txd;
    logic              s_active;

    assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign rd_data = reg_rd && (reg_addr == ADDR_DATA);
    assign run_m   = en_q && !slv_q;
    assign run_s   = en_q && slv_q;

    assign tx_pop      = m_pop || s_pop;
    assign rx_push_any = m_push || s_push;
    assign rx_byte     = slv_q ? s_rx : m_rx;

    assign sclk_o    = m_sclk;
    assign sel_n_o   = m_sel_n;
    assign ser_tx    = slv_q ? s_txd : m_txd;
    assign ser_tx_oe = run_m ? !m_sel_n : s_active;

    // Control and divider registers; slave role forces the 0/0 timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            slv_q  <= 1'b0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            div_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= reg_wdata[CB_EN];
                slv_q  <= reg_wdata[CB_SLV];
                cpol_q <= reg_wdata[CB_POL] && !reg_wdata[CB_SLV];
                cpha_q <= reg_wdata[CB_PHA] && !reg_wdata[CB_SLV];
            end
            if (wr_div) begin
                div_q <= reg_wdata[DIV_W-1:0];
            end
        end
    end

    // Sticky overrun flag: set on a lost byte, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (rx_push_any && rx_full) begin
            ovr_q <= 1'b1;
        end else if (wr_stat && reg_wdata[SB_OVR]) begin
            ovr_q <= 1'b0;
        end
    end

    // Read multiplexer for the register window
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_DATA: reg_rdata = REG_W'(rx_head);
            ADDR_CTRL: begin
                reg_rdata[CB_EN]  = en_q;
                reg_rdata[CB_SLV] = slv_q;
                reg_rdata[CB_POL] = cpol_q;
                reg_rdata[CB_PHA] = cpha_q;
            end
            ADDR_DIV:  reg_rdata = REG_W'(div_q);
            default: begin
                reg_rdata[SB_TXE]  = tx_empty;
                reg_rdata[SB_TXF]  = tx_full;
                reg_rdata[SB_RXE]  = rx_empty;
                reg_rdata[SB_RXF]  = rx_full;
                reg_rdata[SB_BUSY] = m_busy || s_active;
                reg_rdata[SB_OVR]  = ovr_q;
            end
        endcase
    end

    sxp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_data),
        .wdata (reg_wdata[DATA_W-1:0]),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sxp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push_any),
        .wdata (rx_byte),
        .pop   (rd_data),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sxp_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_mst (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_m),
        .cpol     (cpol_q),
        .cpha     (cpha_q),
        .div      (div_q),
        .tx_empty (tx_empty),
        .tx_data  (tx_head),
        .rxd      (ser_rx),
        .tx_pop   (m_pop),
        .rx_push  (m_push),
        .rx_data  (m_rx),
        .sclk     (m_sclk),
        .sel_n    (m_sel_n),
        .txd      (m_txd),
        .busy     (m_busy)
    );

    sxp_slave #(.DATA_W(DATA_W)) u_slv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_s),
        .sclk_in  (sclk_i),
        .sel_n_in (sel_n_i),
        .rxd_in   (ser_rx),
        .tx_empty (tx_empty),
        .tx_data  (tx_head),
        .tx_pop   (s_pop),
        .rx_push  (s_push),
        .rx_data  (s_rx),
        .txd      (s_txd),
        .active   (s_active)
    );

    // R10: the slave role never holds a timing other than polarity 0, phase 0
    a_r10_slave_timing: assert property (@(posedge clk) disable iff (!rst_n)
        slv_q |-> (!cpol_q && !cpha_q));

    // R7: overrun stays set until a clearing write
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !(wr_stat && reg_wdata[SB_OVR])) |=> ovr_q);

    // R7: a byte arriving at a full receive queue raises overrun next cycle
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_any && rx_full) |=> ovr_q);

    // R11: in the master role the enable follows the select
    a_r11_oe_master: assert property (@(posedge clk) disable iff (!rst_n)
        (run_m && !m_sel_n) |-> ser_tx_oe);

endmodule

// File: tb/tb_sxp_port.sv
module tb_sxp_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sclk_o;
    logic       sel_n_o;
    logic       sclk_i = 1'b0;
    logic       sel_n_i = 1'b1;
    logic       ser_tx;
    logic       ser_tx_oe;
    logic       ser_rx;
    logic       mon_rx = 1'b0;
    logic       slv_rx = 1'b0;
    logic       slv_test = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench peer model state
    bit         mon_on = 1'b0;
    bit         mcpol = 1'b0;
    bit         mcpha = 1'b0;
    bit         in_frame = 1'b0;
    logic       prev_sclk = 1'b0;
    logic [7:0] mon_sh = 8'd0;
    int         cur_edges = 0;
    int         frames = 0;
    int         cyc = 0;
    int         last_cyc = 0;
    int         gap_min = 0;
    int         gap_max = 0;
    int         idle_bad = 0;
    int         oe_bad = 0;
    int         rx_idx = 0;
    logic [7:0] slv_byte [32];
    logic [7:0] mon_byte [32];
    int         frame_edges [32];
    logic [7:0] txb [32];

    assign ser_rx = slv_test ? slv_rx : mon_rx;

    always #4 clk = ~clk;

    sxp_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sclk_o    (sclk_o),
        .sel_n_o   (sel_n_o),
        .sclk_i    (sclk_i),
        .sel_n_i   (sel_n_i),
        .ser_tx    (ser_tx),
        .ser_tx_oe (ser_tx_oe),
        .ser_rx    (ser_rx)
    );

    // Peer model seen from the bench: samples and drives on the chosen edges
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && mon_on) begin
            if (!in_frame && !sel_n_o) begin
                in_frame = 1'b1;
                cur_edges = 0;
                mon_sh = 8'd0;
                last_cyc = cyc;
                prev_sclk = sclk_o;
                mon_rx = slv_byte[frames][7];
                rx_idx = mcpha ? 7 : 6;
            end else if (in_frame) begin
                if (sclk_o !== prev_sclk) begin
                    if (cyc - last_cyc < gap_min) gap_min = cyc - last_cyc;
                    if (cyc - last_cyc > gap_max) gap_max = cyc - last_cyc;
                    last_cyc = cyc;
                    if ((sclk_o != mcpol) != mcpha) begin
                        mon_sh = {mon_sh[6:0], ser_tx};
                    end else begin
                        if (rx_idx >= 0) mon_rx = slv_byte[frames][rx_idx];
                        rx_idx = rx_idx - 1;
                    end
                    cur_edges = cur_edges + 1;
                    prev_sclk = sclk_o;
                end
                if (sel_n_o) begin
                    in_frame = 1'b0;
                    mon_byte[frames] = mon_sh;
                    frame_edges[frames] = cur_edges;
                    frames = frames + 1;
                end
            end
            if (sel_n_o && (sclk_o != mcpol)) idle_bad = idle_bad + 1;
            if (ser_tx_oe != !sel_n_o) oe_bad = oe_bad + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_monitor();
        mon_on = 1'b0;
        frames = 0;
        gap_min = 1000000;
        gap_max = 0;
        idle_bad = 0;
        oe_bad = 0;
    endtask

    // R1 / R11: values right after reset
    task automatic t_reset();
        logic [7:0] d;
        check(sel_n_o == 1'b1, "R1 reset sel_n_o", sel_n_o, 1);
        check(sclk_o == 1'b0, "R1 reset sclk_o", sclk_o, 0);
        check(ser_tx_oe == 1'b0, "R11 reset ser_tx_oe", ser_tx_oe, 0);
        reg_read(2'd3, d);
        check(d == 8'h05, "R1 reset status", d, 8'h05);
        reg_read(2'd1, d);
        check(d == 8'h00, "R1 reset control", d, 8'h00);
        reg_read(2'd2, d);
        check(d == 8'h00, "R1 reset divider", d, 8'h00);
    endtask

    // R2 R3 R4 R5 R6 R11: one master timing, n frames
    task automatic t_master(input bit pol, input bit pha, input logic [7:0] dv, input int n, input logic [7:0] seed);
        logic [7:0] d;
        clear_monitor();
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, dv);
        mcpol = pol;
        mcpha = pha;
        for (int i = 0; i < n; i++) begin
            txb[i] = seed ^ 8'(i * 53 + 1);
            slv_byte[i] = ~seed ^ 8'(i * 29 + 7);
            reg_write(2'd0, txb[i]);
        end
        reg_write(2'd1, {4'b0, pha, pol, 1'b0, 1'b1});
        mon_on = 1'b1;
        while (frames < n) @(negedge clk);
        repeat (2 * (int'(dv) + 1) + 10) @(negedge clk);
        mon_on = 1'b0;
        for (int i = 0; i < n; i++) begin
            check(mon_byte[i] == txb[i], "R2 R3 transmitted byte", mon_byte[i], txb[i]);
            check(frame_edges[i] == 16, "R2 edges per frame", frame_edges[i], 16);
        end
        check(gap_min == int'(dv) + 1, "R4 shortest edge spacing", gap_min, int'(dv) + 1);
        check(gap_max == int'(dv) + 1, "R4 longest edge spacing", gap_max, int'(dv) + 1);
        check(idle_bad == 0, "R3 idle clock level", idle_bad, 0);
        check(oe_bad == 0, "R11 master output enable", oe_bad, 0);
        check(frames == n, "R5 frame count", frames, n);
        for (int i = 0; i < n; i++) begin
            reg_read(2'd0, d);
            check(d == slv_byte[i], "R3 R6 received byte", d, slv_byte[i]);
        end
        reg_read(2'd3, d);
        check(d == 8'h05, "R5 status after frames", d, 8'h05);
    endtask

    // R5 R6 R7 R8: fill both queues to their ends
    task automatic t_limits();
        logic [7:0] d;
        clear_monitor();
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'd1);
        mcpol = 1'b0;
        mcpha = 1'b0;
        for (int i = 0; i < 10; i++) begin
            txb[i] = 8'hA0 + 8'(i * 3);
            slv_byte[i] = 8'h11 * 8'(i + 1);
        end
        for (int i = 0; i < 9; i++) reg_write(2'd0, txb[i]);
        reg_read(2'd3, d);
        check(d == 8'h06, "R8 status with full transmit queue", d, 8'h06);
        reg_write(2'd1, 8'h01);
        mon_on = 1'b1;
        while (frames < 8) @(negedge clk);
        repeat (60) @(negedge clk);
        check(frames == 8, "R8 dropped ninth byte", frames, 8);
        check(mon_byte[7] == txb[7], "R8 last queued byte sent", mon_byte[7], txb[7]);
        check(idle_bad == 0, "R5 clock idle with empty queue", idle_bad, 0);
        reg_read(2'd3, d);
        check(d == 8'h09, "R6 status with full receive queue", d, 8'h09);
        reg_write(2'd0, txb[9]);
        while (frames < 9) @(negedge clk);
        repeat (10) @(negedge clk);
        check(mon_byte[8] == txb[9], "R5 frame after refill", mon_byte[8], txb[9]);
        reg_read(2'd3, d);
        check(d == 8'h29, "R7 overrun set", d, 8'h29);
        for (int i = 0; i < 8; i++) begin
            reg_read(2'd0, d);
            check(d == slv_byte[i], "R7 held bytes kept", d, slv_byte[i]);
        end
        reg_read(2'd3, d);
        check(d == 8'h25, "R7 overrun holds after reads", d, 8'h25);
        reg_write(2'd3, 8'h20);
        reg_read(2'd3, d);
        check(d == 8'h05, "R7 overrun cleared", d, 8'h05);
        mon_on = 1'b0;
    endtask

    // R9 R10 R11: slave role with two bytes under one select
    task automatic t_slave();
        logic [7:0] d;
        logic [7:0] sb [2];
        logic [7:0] st [2];
        logic [7:0] got [2];
        sb[0] = 8'h4D;
        sb[1] = 8'hB2;
        st[0] = 8'hC6;
        st[1] = 8'h3B;
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, st[0]);
        reg_write(2'd0, st[1]);
        reg_write(2'd1, 8'h0F);
        reg_read(2'd1, d);
        check(d == 8'h03, "R10 slave timing forced to 0/0", d, 8'h03);
        slv_test = 1'b1;
        repeat (4) @(negedge clk);
        check(ser_tx_oe == 1'b0, "R11 slave enable before select", ser_tx_oe, 0);
        check(sel_n_o == 1'b1 && sclk_o == 1'b0, "R11 master pins idle in slave role", {sel_n_o, sclk_o}, 2);
        sel_n_i = 1'b0;
        repeat (8) @(negedge clk);
        check(ser_tx_oe == 1'b1, "R11 slave enable in select", ser_tx_oe, 1);
        for (int k = 0; k < 2; k++) begin
            got[k] = 8'd0;
            for (int b = 7; b >= 0; b--) begin
                slv_rx = sb[k][b];
                repeat (5) @(negedge clk);
                got[k] = {got[k][6:0], ser_tx};
                sclk_i = 1'b1;
                repeat (6) @(negedge clk);
                sclk_i = 1'b0;
                repeat (6) @(negedge clk);
            end
        end
        sel_n_i = 1'b1;
        repeat (8) @(negedge clk);
        check(ser_tx_oe == 1'b0, "R11 slave enable after select", ser_tx_oe, 0);
        for (int k = 0; k < 2; k++) begin
            check(got[k] == st[k], "R9 slave transmitted byte", got[k], st[k]);
            reg_read(2'd0, d);
            check(d == sb[k], "R9 slave received byte", d, sb[k]);
        end
        reg_read(2'd3, d);
        check(d == 8'h05, "R9 status after slave frames", d, 8'h05);
        slv_test = 1'b0;
        reg_write(2'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master(1'b0, 1'b0, 8'd0, 3, 8'h5A);
        t_master(1'b0, 1'b1, 8'd1, 3, 8'h81);
        t_master(1'b1, 1'b0, 8'd3, 3, 8'hE7);
        t_master(1'b1, 1'b1, 8'd2, 3, 8'h3C);
        t_limits();
        t_slave();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule